// File: doc/BRIEF.md
# UART Receive Error-Tagging Queue

This block sits between a UART bit deserializer and the CPU register interface. Each received character arrives with two flags: a parity flag and a framing flag. The block stores the character and its flags together in a small receive queue. The block also watches the raw serial line. When the line stays low for longer than one whole frame, the block declares a line break and queues a single all-zero character that carries a break tag.

The status byte shows the tags of the character at the head of the queue, and only that character's tags. A tag stays visible until the first status read made while that character is at the head. A summary bit stays set while any tagged character is still anywhere in the queue. An overrun flag records characters that were dropped because the queue was full. A receiver line-status interrupt request is raised when it is enabled and any of the error bits is showing.

There are two modes. In queue mode the queue holds up to `DEPTH` characters. In single-holding mode it holds one character and the summary bit is forced to zero.

Top module: `uart_rxq_top`

## Requirements
- R1: A break is declared when `rxd` is sampled low on more than FRAME_CYC = (1 + DATA_BITS + PARITY_BITS + STOP_BITS) × BIT_CYC consecutive clock edges. A low run of FRAME_CYC edges or fewer declares nothing.
- R2: Each break queues exactly one entry, with data 0x00 and the break tag set, however long the line stays low. The detector re-arms only after it samples `rxd` high. If the deserializer pushes a character in the same cycle, the break entry waits for the next cycle without one.
- R3: Status bit 0 is 1 exactly when the queue is non-empty. `rbr` shows the head character, and a `rd_rbr` pulse removes the head.
- R4: Status bits 2, 3 and 4 are the parity, framing and break tags of the head character. They are shown only until the first `rd_lsr` made while that character is the head. A character that reaches the head later shows its own tags.
- R5: Status bit 1 (overrun) is set when a character or break entry arrives while the queue is full. Fullness is judged before any pop in the same cycle. The arriving entry is dropped and the stored contents stay unchanged. The bit is cleared by `rd_lsr` unless a new overrun happens in that same cycle.
- R6: In queue mode, status bit 7 is 1 while at least one entry in the queue has any tag. It stays 1 after a status read if tagged entries remain, and it drops once the last tagged entry is popped.
- R7: With `fifo_en` low, the queue holds one character, so a second arrival is an overrun, and status bit 7 reads 0.
- R8: `rls_irq` is 1 exactly when `ier_rls` is 1 and any of status bits 1 to 4 is 1.
- R9: A `flush` pulse empties the queue and clears the tag summary.
- R10: Status bits 5 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single-holding mode |
| flush | input | 1 | Synchronous queue clear |
| ier_rls | input | 1 | Line-status interrupt enable |
| rxd | input | 1 | Raw serial line, used for break detection |
| ch_valid | input | 1 | Deserializer delivers a character this cycle |
| ch_data | input | 8 | Received character |
| ch_perr | input | 1 | Parity error flag for `ch_data` |
| ch_ferr | input | 1 | Framing error flag for `ch_data` |
| rd_lsr | input | 1 | CPU status-read pulse |
| rd_rbr | input | 1 | CPU data-read pulse (pops the head) |
| lsr | output | 8 | Status: bit0 ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break, bit7 any tag queued |
| rbr | output | 8 | Head character |
| rls_irq | output | 1 | Receiver line-status interrupt request |

## Verification
The queue is filled to capacity with a sweep of data values that covers every combination of parity and framing flags. It is then drained with status reads interleaved. This separates the head-only view of the tags from the whole-queue summary, and shows that each tag is hidden after its first read. Low runs of exactly the frame length, one edge longer, and many frames long separate the detection threshold from the single-entry rule. Arrivals at capacity, both alone and together with a pop, and arrivals in single-holding mode separate overrun from normal storage. Toggling the interrupt enable shows that the request follows the error bits only when it is allowed to.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        BRK_IDLE,
        BRK_LOW,
        BRK_HELD
    } brk_state_e;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/uart_rxq_brkdet.sv
module uart_rxq_brkdet
    import uart_rxq_pkg::*;
#(
    parameter int FRAME_CYC = 176
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       fire,
    output brk_state_e state_o
);
    localparam int CW = $clog2(FRAME_CYC + 1);

    brk_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            BRK_IDLE: begin
                if (!rxd) begin
                    state_d = BRK_LOW;
                    cnt_d   = CW'(1);
                end
            end
            BRK_LOW: begin
                if (rxd) begin
                    state_d = BRK_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(FRAME_CYC)) begin
                    state_d = BRK_HELD;
                    cnt_d   = '0;
                    fire    = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            BRK_HELD: begin
                if (rxd) state_d = BRK_IDLE;
            end
            default: state_d = BRK_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       cap_one,
    input  logic       push,
    input  rxq_entry_t push_ent,
    input  logic       pop,
    output rxq_entry_t head,
    output logic [CW-1:0] cnt,
    output logic       full,
    output logic       empty,
    output logic [CW-1:0] tag_cnt,
    output logic       acc_push,
    output logic       acc_pop
);
    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q, tag_q;
    logic          push_tagged, head_tagged;

    assign empty    = (cnt_q == '0);
    assign full     = cap_one ? !empty : (cnt_q == CW'(DEPTH));
    assign acc_push = push && !full;
    assign acc_pop  = pop && !empty;
    assign head     = mem[rd_q];

    assign push_tagged = push_ent.brk | push_ent.ferr | push_ent.perr;
    assign head_tagged = head.brk | head.ferr | head.perr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (acc_push && !flush) mem[wr_q] <= push_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            tag_q <= '0;
        end else if (flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            tag_q <= '0;
        end else begin
            if (acc_push) wr_q <= bump(wr_q);
            if (acc_pop)  rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CW'(acc_push) - CW'(acc_pop);
            tag_q <= tag_q + CW'(acc_push && push_tagged)
                           - CW'(acc_pop && head_tagged);
        end
    end

    assign cnt     = cnt_q;
    assign tag_cnt = tag_q;
endmodule

// File: rtl/uart_rxq_stat.sv
module uart_rxq_stat (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       ier_rls,
    input  logic       rd_lsr,
    input  logic       flush,
    input  logic       empty,
    input  logic       acc_pop,
    input  logic       rej_push,
    input  logic [2:0] head_tags,
    input  logic       any_tag,
    output logic [7:0] lsr,
    output logic       irq
);
    logic       seen_q, oe_q;
    logic [2:0] vis;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            if (flush || acc_pop)        seen_q <= 1'b0;
            else if (rd_lsr && !empty)   seen_q <= 1'b1;

            if (rej_push)                oe_q <= 1'b1;
            else if (rd_lsr)             oe_q <= 1'b0;
        end
    end

    assign vis = (empty || seen_q) ? 3'b000 : head_tags;
    assign lsr = {fifo_en & any_tag, 2'b00, vis[2], vis[1], vis[0], oe_q, !empty};
    assign irq = ier_rls & (oe_q | (|vis));
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int BIT_CYC     = 16,
    parameter int DATA_BITS   = 8,
    parameter int PARITY_BITS = 1,
    parameter int STOP_BITS   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       flush,
    input  logic       ier_rls,
    input  logic       rxd,
    input  logic       ch_valid,
    input  logic [7:0] ch_data,
    input  logic       ch_perr,
    input  logic       ch_ferr,
    input  logic       rd_lsr,
    input  logic       rd_rbr,
    output logic [7:0] lsr,
    output logic [7:0] rbr,
    output logic       rls_irq
);
    localparam int FRAME_CYC = (1 + DATA_BITS + PARITY_BITS + STOP_BITS) * BIT_CYC;
    localparam int CW        = $clog2(DEPTH) + 1;

    logic          brk_fire, brk_pend_q, push, full, empty, acc_push, acc_pop, rej_push;
    brk_state_e    brk_state;
    rxq_entry_t    push_ent, head;
    logic [CW-1:0] cnt, tag_cnt;

    uart_rxq_brkdet #(.FRAME_CYC(FRAME_CYC)) u_brk (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .fire(brk_fire), .state_o(brk_state)
    );

    // break entry waits for a cycle without a deserializer character
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       brk_pend_q <= 1'b0;
        else if (brk_fire)                brk_pend_q <= 1'b1;
        else if (brk_pend_q && !ch_valid) brk_pend_q <= 1'b0;
    end

    assign push     = ch_valid | brk_pend_q;
    assign push_ent = ch_valid ? '{brk: 1'b0, ferr: ch_ferr, perr: ch_perr, data: ch_data}
                               : '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};
    assign rej_push = push && full;

    uart_rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cap_one(!fifo_en),
        .push(push), .push_ent(push_ent), .pop(rd_rbr),
        .head(head), .cnt(cnt), .full(full), .empty(empty), .tag_cnt(tag_cnt),
        .acc_push(acc_push), .acc_pop(acc_pop)
    );

    uart_rxq_stat u_stat (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ier_rls(ier_rls),
        .rd_lsr(rd_lsr), .flush(flush), .empty(empty), .acc_pop(acc_pop),
        .rej_push(rej_push), .head_tags({head.brk, head.ferr, head.perr}),
        .any_tag(tag_cnt != '0), .lsr(lsr), .irq(rls_irq)
    );

    assign rbr = head.data;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk
    import uart_rxq_pkg::*;
#(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          ier_rls,
    input logic          rxd,
    input logic          ch_valid,
    input logic          rd_lsr,
    input logic          rd_rbr,
    input logic [7:0]    lsr,
    input logic          rls_irq,
    input logic          full,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] tag_cnt,
    input brk_state_e    brk_state,
    input logic          brk_fire
);
    a_r1_fire_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        brk_fire |-> !rxd);

    a_r2_one_per_low: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_state == BRK_HELD) |-> !brk_fire);

    a_r3_ready_matches: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[0] == (cnt != '0));

    a_r4_hidden_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && lsr[0] && !rd_rbr && !flush) |=> (lsr[4:2] == 3'b000));

    a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && full) |=> lsr[1]);

    a_r6_tags_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tag_cnt <= cnt);

    a_r8_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        rls_irq |-> ier_rls);

    a_r10_tx_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6:5] == 2'b00);
endmodule

bind uart_rxq_top uart_rxq_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ier_rls(ier_rls), .rxd(rxd),
    .ch_valid(ch_valid), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .lsr(lsr),
    .rls_irq(rls_irq), .full(full), .cnt(cnt), .tag_cnt(tag_cnt),
    .brk_state(brk_state), .brk_fire(brk_fire)
);

// File: tb/uart_rxq_top_tb.sv
module uart_rxq_top_tb;
    localparam int DEPTH = 16;
    localparam int BITC  = 2;
    localparam int FRAME = (1 + 8 + 1 + 1) * BITC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 1'b1, flush = 1'b0, ier_rls = 1'b1, rxd = 1'b1;
    logic ch_valid = 1'b0, ch_perr = 1'b0, ch_ferr = 1'b0, rd_lsr = 1'b0, rd_rbr = 1'b0;
    logic [7:0] ch_data = 8'h00;
    logic [7:0] lsr, rbr;
    logic rls_irq;

    int n_chk = 0, n_bad = 0;

    logic [10:0] mq [64];
    int m_h = 0, m_cnt = 0;
    logic m_seen = 1'b0, m_oe = 1'b0;

    always #5 clk = ~clk;

    uart_rxq_top #(.DEPTH(DEPTH), .BIT_CYC(BITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush), .ier_rls(ier_rls),
        .rxd(rxd), .ch_valid(ch_valid), .ch_data(ch_data), .ch_perr(ch_perr),
        .ch_ferr(ch_ferr), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
        .lsr(lsr), .rbr(rbr), .rls_irq(rls_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_lsr();
        logic [10:0] hd;
        logic vis, any;
        any = 1'b0;
        for (int i = 0; i < m_cnt; i++) any |= |mq[(m_h + i) % 64][10:8];
        hd  = mq[m_h];
        vis = (m_cnt > 0) && !m_seen;
        return {fifo_en & any, 2'b00, vis & hd[10], vis & hd[9], vis & hd[8], m_oe, m_cnt > 0};
    endfunction

    task automatic check_all(input string tag);
        logic [7:0] e;
        e = exp_lsr();
        check({tag, " lsr"}, int'(lsr), int'(e));
        check({tag, " R8 irq"}, int'(rls_irq), int'(ier_rls & (|e[4:1])));
        if (m_cnt > 0) check({tag, " R3 rbr"}, int'(rbr), int'(mq[m_h][7:0]));
    endtask

    task automatic model_push(input logic [10:0] ent);
        int cap;
        cap = fifo_en ? DEPTH : 1;
        if (m_cnt >= cap) m_oe = 1'b1;
        else begin
            mq[(m_h + m_cnt) % 64] = ent;
            m_cnt++;
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [7:0] d,
                        input logic p, input logic f, input logic rl,
                        input logic rr, input logic fl);
        int cap, prev;
        logic popok, pushok;
        @(negedge clk);
        ch_valid = v; ch_data = d; ch_perr = p; ch_ferr = f;
        rd_lsr = rl; rd_rbr = rr; flush = fl;
        @(negedge clk);
        ch_valid = 0; ch_perr = 0; ch_ferr = 0; rd_lsr = 0; rd_rbr = 0; flush = 0;
        cap = fifo_en ? DEPTH : 1;
        prev = m_cnt;
        popok = rr && (m_cnt > 0);
        pushok = v && (m_cnt < cap);
        if (v && !pushok) m_oe = 1'b1;
        else if (rl) m_oe = 1'b0;
        if (fl) begin
            m_cnt = 0; m_seen = 1'b0;
        end else begin
            if (popok) begin m_h = (m_h + 1) % 64; m_cnt--; end
            if (pushok) begin mq[(m_h + m_cnt) % 64] = {1'b0, f, p, d}; m_cnt++; end
            if (popok) m_seen = 1'b0;
            else if (rl && prev > 0) m_seen = 1'b1;
        end
        check_all(tag);
    endtask

    task automatic line_low(input string tag, input int n, input logic brk_exp);
        @(negedge clk);
        rxd = 1'b0;
        repeat (n) @(negedge clk);
        rxd = 1'b1;
        repeat (3) @(negedge clk);
        if (brk_exp) model_push(11'h400);
        check_all(tag);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset lsr", int'(lsr), 0);
        check("R8 reset irq", int'(rls_irq), 0);

        // R6 R4: fill with every parity/framing combination
        for (int i = 0; i < DEPTH; i++)
            step("R6 fill", 1, 8'(i * 17 + 3), i[0], i[1], 0, 0, 0);
        // R5: arrival at capacity, alone and with a pop
        step("R5 overrun", 1, 8'hEE, 1, 1, 0, 0, 0);
        step("R5 clear on read", 0, 0, 0, 0, 1, 0, 0);
        step("R5 full with pop", 1, 8'hDD, 0, 0, 0, 1, 0);
        // R4 R6: drain with status reads interleaved
        for (int i = 0; i < DEPTH - 1; i++) begin
            step("R4 head view", 0, 0, 0, 0, 1, 0, 0);
            step("R6 pop", 0, 0, 0, 0, 0, 1, 0);
        end
        check("R6 empty summary", int'(lsr[7]), 0);

        // R1 R2: break thresholds
        line_low("R1 exact frame", FRAME, 0);
        line_low("R1 one past frame", FRAME + 1, 1);
        line_low("R2 long low", FRAME * 5, 1);
        check("R2 two entries", int'(m_cnt), 2);
        step("R2 read", 0, 0, 0, 0, 1, 0, 0);
        step("R2 pop", 0, 0, 0, 0, 0, 1, 0);
        step("R2 pop", 0, 0, 0, 0, 0, 1, 0);

        // R8: enable gating
        step("R8 tagged", 1, 8'h5A, 1, 0, 0, 0, 0);
        ier_rls = 1'b0;
        @(negedge clk);
        check_all("R8 disabled");
        ier_rls = 1'b1;
        // same-cycle push and pop
        step("R3 push", 1, 8'h11, 0, 0, 0, 0, 0);
        step("R3 push+pop", 1, 8'h22, 0, 1, 0, 1, 0);
        // R9: flush
        step("R9 flush", 0, 0, 0, 0, 0, 0, 1);
        check("R9 empty", int'(lsr), 0);

        // R7: single-holding mode
        fifo_en = 1'b0;
        @(negedge clk);
        step("R7 hold", 1, 8'h77, 1, 0, 0, 0, 0);
        step("R7 second", 1, 8'h78, 0, 1, 0, 0, 0);
        check("R7 summary zero", int'(lsr[7]), 0);
        step("R7 read", 0, 0, 0, 0, 1, 0, 0);
        step("R7 pop", 0, 0, 0, 0, 0, 1, 0);
        line_low("R7 break", FRAME + 2, 1);
        step("R7 pop break", 0, 0, 0, 0, 0, 1, 0);
        check("R10 tx bits", int'(lsr[6:5]), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule